// File: doc/BRIEF.md
# Triple-Copy SPI EEPROM Configuration Loader

After reset this block fetches a device configuration from an external serial EEPROM and writes it into a byte-wide register file. It acts as an SPI master. The area it fetches is chosen by a 3-bit select input, which is sampled once, in the first clock cycle after reset is released.

Each area holds three copies of the same register image. The block reads the first copy in one burst. It writes those bytes straight into the register file and raises `run`, so the device can start working without waiting for the rest. It then reads the second and third copies in two further bursts. As the third copy arrives, it rewrites every register with the bitwise two-of-three majority of the three copies and pulses `done` once.

An `active` output follows bit 6 of register 10, gated by `run`. Asserting reset at any time abandons the load. The whole sequence starts again when reset is released.

Top module: `cfg_loader`

## Requirements
- R1: The select value is taken from `cfg_sel` in the first clock cycle with `rst_n` high; changes to `cfg_sel` after that do not alter which area is read until the next reset release.
- R2: The serial link is SPI mode 0: `spi_sclk` is low whenever `spi_cs_n` is high, `spi_mosi` changes only while `spi_sclk` is low, bits go most significant first, and every high phase of `spi_sclk` lasts exactly HALF_PERIOD_CYC clock cycles.
- R3: Every burst opens with the command byte whose bits 7..4 are 0, bit 3 is bit 8 of the start address and bits 2..0 are 3'b011, followed by a byte holding address bits 7..0.
- R4: MEM_KBIT of 1, 2 or 4 gives 2, 4 or 8 areas of 64 bytes; the area index is the low log2(areas) bits of the select, the area starts at index*64, and copy k (k = 0, 1, 2) starts at area start + k*REG_BYTES.
- R5: The bytes of copy 0 are written to register addresses 0 up to REG_BYTES-1 as they arrive; `run` rises in the cycle after the write of the last of them and then stays high until reset.
- R6: Each copy is read in its own chip-select burst (three bursts per load); `done` is a single-cycle pulse that comes with the last voted write, only once per reset release and only while `run` is high.
- R7: In the third burst, every register address is written once more with the bitwise majority of its three copies, so a load makes exactly 2*REG_BYTES writes and the register file ends with the voted image.
- R8: `active` equals `run` AND bit 6 of the most recent value written to register address 10, and follows a write one cycle later.
- R9: While `rst_n` is low, the block holds `spi_cs_n` high and `run`, `done`, `active` and `rf_we` low from the next clock edge. Reset may come mid-transfer, and the load restarts from copy 0 on release.
- R10: After the address byte of a burst, `spi_mosi` stays low until chip select is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts a load |
| cfg_sel | input | 3 | Configuration area select |
| spi_sclk | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Command and address to the EEPROM |
| spi_miso | input | 1 | Data from the EEPROM |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | AW | Register file byte address |
| rf_wdata | output | 8 | Register file write data |
| run | output | 1 | First copy applied |
| done | output | 1 | One-cycle pulse when the voted image is committed |
| active | output | 1 | Run gated by bit 6 of register 10 |

## Verification
The EEPROM areas are filled with random bytes in four patterns, each of which tells a different fault apart:
- Three independent copies exercise the vote on every bit.
- Identical copies show that a faithful image passes unchanged.
- A deviating third copy shows that the vote, and not the last byte received, decides.
- A deviating first copy makes the image seen at `run` differ from the final image, which separates the early write from the voted one.

Select values on both sides of address 256 check the address bit carried in the command byte. The select is changed after release to confirm it is ignored. A reset in the middle of the second burst checks the abort and a clean restart.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

    // Register and bit that gate the device after loading
    localparam int ACT_REG_ADDR = 10;
    localparam int ACT_BIT      = 6;

    // Each configuration area is 64 bytes for every supported size
    localparam int AREA_SIZE = 64;

    localparam logic [2:0] RD_CODE = 3'b011;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_XFER,
        SQ_GAP,
        SQ_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA
    } xfer_phase_e;

    function automatic logic [7:0] read_opcode(input logic hi_addr);
        return {4'b0000, hi_addr, RD_CODE};
    endfunction

    function automatic logic [7:0] vote3(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cfgload_spi_byte.sv
module cfgload_spi_byte #(
    parameter int HALF_PERIOD_CYC = 62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = $clog2(HALF_PERIOD_CYC + 1);

    logic          busy;
    logic [CW-1:0] tick;
    logic [2:0]    bit_idx;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tick    <= '0;
            bit_idx <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sh_tx   <= tx_byte;
                    mosi    <= tx_byte[7];
                    bit_idx <= 3'd7;
                    tick    <= '0;
                    sclk    <= 1'b0;
                end
            end else if (tick == CW'(HALF_PERIOD_CYC - 1)) begin
                tick <= '0;
                if (!sclk) begin
                    // rising edge: capture the incoming bit
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    // falling edge: present the next outgoing bit
                    sclk <= 1'b0;
                    if (bit_idx == 3'd0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        mosi <= 1'b0;
                    end else begin
                        bit_idx <= bit_idx - 3'd1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                        mosi    <= sh_tx[6];
                    end
                end
            end else begin
                tick <= tick + CW'(1);
            end
        end
    end

    assign rx_byte = sh_rx;

    AST_MOSI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk); // R2

endmodule

// File: rtl/cfgload_vote.sv
module cfgload_vote
    import cfgload_pkg::*;
#(
    parameter int REG_BYTES = 16,
    parameter int AW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_valid,
    input  logic [1:0]    beat_copy,
    input  logic [AW-1:0] beat_idx,
    input  logic          beat_last,
    input  logic [7:0]    beat_data,
    output logic          rf_we,
    output logic [AW-1:0] rf_addr,
    output logic [7:0]    rf_wdata,
    output logic          first_ready,
    output logic          vote_ready
);
    logic [7:0] copy_a [REG_BYTES];
    logic [7:0] copy_b [REG_BYTES];

    // Copies 0 and 1 are held until the third copy streams in
    always_ff @(posedge clk) begin
        if (beat_valid && beat_copy == 2'd0) copy_a[beat_idx] <= beat_data;
        if (beat_valid && beat_copy == 2'd1) copy_b[beat_idx] <= beat_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we       <= 1'b0;
            rf_addr     <= '0;
            rf_wdata    <= '0;
            first_ready <= 1'b0;
            vote_ready  <= 1'b0;
        end else begin
            rf_we       <= 1'b0;
            first_ready <= 1'b0;
            vote_ready  <= 1'b0;
            if (beat_valid && beat_copy != 2'd1) begin
                rf_we       <= 1'b1;
                rf_addr     <= beat_idx;
                rf_wdata    <= (beat_copy == 2'd0) ? beat_data
                             : vote3(copy_a[beat_idx], copy_b[beat_idx], beat_data);
                first_ready <= (beat_copy == 2'd0) && beat_last;
                vote_ready  <= (beat_copy == 2'd2) && beat_last;
            end
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (int'(rf_addr) < REG_BYTES)); // R7
    AST_VOTE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        vote_ready |-> rf_we); // R6

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgload_pkg::*;
#(
    parameter int HALF_PERIOD_CYC = 62,
    parameter int MEM_KBIT        = 4,
    parameter int REG_BYTES       = 16,
    localparam int AW             = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_sel,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          rf_we,
    output logic [AW-1:0] rf_addr,
    output logic [7:0]    rf_wdata,
    output logic          run,
    output logic          done,
    output logic          active
);
    localparam int AREAS = MEM_KBIT * 2;
    localparam int SEL_W = (AREAS > 1) ? $clog2(AREAS) : 1;
    localparam int GW    = $clog2(HALF_PERIOD_CYC + 1);

    seq_state_e  state;
    xfer_phase_e phase;
    logic [SEL_W-1:0] sel_q;
    logic [1:0]       copy_q;
    logic [AW-1:0]    byte_q;
    logic [GW-1:0]    gap_q;
    logic [8:0]       start_addr;
    logic             last_byte;

    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    logic beat_valid;
    logic first_ready;
    logic vote_ready;
    logic run_q;
    logic act_q;

    always_comb begin
        start_addr = 9'(sel_q) * 9'(AREA_SIZE) + 9'(copy_q) * 9'(REG_BYTES);
    end

    assign last_byte  = (byte_q == AW'(REG_BYTES - 1));
    assign beat_valid = (state == SQ_XFER) && (phase == PH_DATA) && eng_done;

    always_comb begin
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        case (state)
            SQ_OPEN: begin
                eng_start = 1'b1;
                eng_tx    = read_opcode(start_addr[8]);
            end
            SQ_XFER: begin
                if (eng_done) begin
                    if (phase == PH_OPCODE) begin
                        eng_start = 1'b1;
                        eng_tx    = start_addr[7:0];
                    end else if (phase == PH_ADDR) begin
                        eng_start = 1'b1;
                    end else if (!last_byte) begin
                        eng_start = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            phase    <= PH_OPCODE;
            sel_q    <= '0;
            copy_q   <= '0;
            byte_q   <= '0;
            gap_q    <= '0;
            spi_cs_n <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    sel_q  <= cfg_sel[SEL_W-1:0];
                    copy_q <= 2'd0;
                    state  <= SQ_OPEN;
                end
                SQ_OPEN: begin
                    spi_cs_n <= 1'b0;
                    phase    <= PH_OPCODE;
                    state    <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (eng_done) begin
                        case (phase)
                            PH_OPCODE: phase <= PH_ADDR;
                            PH_ADDR: begin
                                phase  <= PH_DATA;
                                byte_q <= '0;
                            end
                            default: begin
                                if (last_byte) begin
                                    spi_cs_n <= 1'b1;
                                    gap_q    <= '0;
                                    state    <= SQ_GAP;
                                end else begin
                                    byte_q <= byte_q + AW'(1);
                                end
                            end
                        endcase
                    end
                end
                SQ_GAP: begin
                    if (gap_q == GW'(HALF_PERIOD_CYC)) begin
                        if (copy_q == 2'd2) begin
                            state <= SQ_HOLD;
                        end else begin
                            copy_q <= copy_q + 2'd1;
                            state  <= SQ_OPEN;
                        end
                    end else begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
                default: state <= SQ_HOLD;
            endcase
        end
    end

    cfgload_spi_byte #(
        .HALF_PERIOD_CYC(HALF_PERIOD_CYC)
    ) u_spi (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .tx_byte(eng_tx),
        .done   (eng_done),
        .rx_byte(eng_rx),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .miso   (spi_miso)
    );

    cfgload_vote #(
        .REG_BYTES(REG_BYTES),
        .AW       (AW)
    ) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_copy  (copy_q),
        .beat_idx   (byte_q),
        .beat_last  (last_byte),
        .beat_data  (eng_rx),
        .rf_we      (rf_we),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .first_ready(first_ready),
        .vote_ready (vote_ready)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            act_q <= 1'b0;
        end else begin
            if (first_ready) run_q <= 1'b1;
            if (rf_we && rf_addr == AW'(ACT_REG_ADDR)) act_q <= rf_wdata[ACT_BIT];
        end
    end

    assign run    = run_q;
    assign done   = vote_ready;
    assign active = run_q & act_q;

    AST_RESET_QUIETS: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !run && !done && !rf_we)); // R9
    AST_RUN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run); // R6
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R2
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE) |=> $stable(sel_q)); // R1
    AST_MOSI_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_XFER && phase == PH_DATA) |-> !spi_mosi); // R10

endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
    localparam int HALF_PERIOD_CYC = 2;
    localparam int MEM_KBIT        = 4;
    localparam int REG_BYTES       = 16;
    localparam int AREA            = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       spi_miso = 1'b0;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       rf_we, run, done, active;
    logic [3:0] rf_addr;
    logic [7:0] rf_wdata;

    always #2 clk = ~clk;

    cfg_loader #(
        .HALF_PERIOD_CYC(HALF_PERIOD_CYC),
        .MEM_KBIT       (MEM_KBIT),
        .REG_BYTES      (REG_BYTES)
    ) u_cfg_loader (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .run(run), .done(done), .active(active)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // ---------------- EEPROM model ----------------
    logic [7:0]  mem [0:511];
    int          bitcnt = 0;
    logic [15:0] cmd = '0;
    int          burst_n = 0;
    logic [7:0]  burst_op [0:7];
    logic [7:0]  burst_lo [0:7];
    int          mosi_hi = 0;

    always @(negedge spi_cs_n) bitcnt = 0;

    always @(posedge spi_cs_n) begin
        if (bitcnt >= 16 && burst_n < 8) begin
            burst_op[burst_n] = cmd[15:8];
            burst_lo[burst_n] = cmd[7:0];
            burst_n++;
        end
        bitcnt = 0;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (bitcnt < 16) cmd = {cmd[14:0], spi_mosi};
            else if (spi_mosi) mosi_hi++;
            bitcnt++;
        end
    end

    always @(negedge spi_sclk) begin
        int         off;
        logic [8:0] a;
        if (!spi_cs_n && bitcnt >= 16) begin
            off      = bitcnt - 16;
            a        = {cmd[11], cmd[7:0]} + 9'(off / 8);
            spi_miso = mem[a][7 - (off % 8)];
        end
    end

    // ---------------- output monitor ----------------
    logic [7:0] shadow [0:15];
    logic [7:0] snap   [0:15];
    int   wr_count = 0, done_count = 0, run_rises = 0;
    int   hi_len = 0, hi_bad = 0, cs_bad = 0;
    logic run_prev = 1'b0;

    always @(negedge clk) begin
        if (rf_we) begin
            shadow[rf_addr] = rf_wdata;
            wr_count++;
        end
        if (run && !run_prev) begin
            for (int i = 0; i < REG_BYTES; i++) snap[i] = shadow[i];
            run_rises++;
        end
        run_prev = run;
        if (done) done_count++;
        if (spi_sclk) hi_len++;
        else begin
            if (hi_len != 0 && hi_len != HALF_PERIOD_CYC) hi_bad++;
            hi_len = 0;
        end
        if (spi_sclk && spi_cs_n) cs_bad++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "R6 watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

    // ---------------- expected values ----------------
    function automatic logic [7:0] exp_vote(input int base, input int i);
        logic [7:0] a, b, c;
        a = mem[base + i];
        b = mem[base + REG_BYTES + i];
        c = mem[base + 2 * REG_BYTES + i];
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic fill(input int base, input int mode);
        for (int i = 0; i < REG_BYTES; i++) begin
            logic [7:0] r, c0, c1, c2;
            r = 8'($urandom);
            if (i == 10) r[6] = (mode != 1);
            case (mode)
                0: begin c0 = 8'($urandom); c1 = 8'($urandom); c2 = 8'($urandom); end
                1: begin c0 = r; c1 = r; c2 = r; end
                2: begin c0 = r; c1 = r; c2 = ~r; end
                default: begin c0 = ~r; c1 = r; c2 = r; end
            endcase
            mem[base + i]                 = c0;
            mem[base + REG_BYTES + i]     = c1;
            mem[base + 2 * REG_BYTES + i] = c2;
        end
    endtask

    task automatic reset_and_release(input int sel, input int base);
        @(negedge clk);
        rst_n   = 1'b0;
        cfg_sel = 3'(sel);
        repeat (3) @(negedge clk);
        // R9: quiet outputs in reset
        chk({spi_cs_n, run, done, active, rf_we} == 5'b10000, "R9 reset state",
            int'({spi_cs_n, run, done, active, rf_we}), 16);
        burst_n = 0; mosi_hi = 0; wr_count = 0; done_count = 0; run_rises = 0;
        hi_bad = 0; cs_bad = 0;
        for (int i = 0; i < REG_BYTES; i++) shadow[i] = ~exp_vote(base, i);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cfg_sel = 3'(sel + 3); // R1: late change must be ignored
    endtask

    task automatic run_load(input int sel, input int mode);
        int base, t, bad5, bad7;
        base = sel * AREA;
        fill(base, mode);
        reset_and_release(sel, base);
        t = 0;
        while (done_count == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (40) @(negedge clk);

        chk(done_count == 1, "R6 single done pulse", done_count, 1);
        chk(burst_n == 3, "R6 three bursts", burst_n, 3);
        chk(burst_lo[0] == 8'(base), "R1 select captured at release", burst_lo[0], base % 256);
        for (int k = 0; k < 3; k++) begin
            logic [8:0] e;
            e = 9'(base + k * REG_BYTES);
            chk(burst_op[k] == {4'b0000, e[8], 3'b011}, "R3 command byte",
                burst_op[k], {4'b0000, e[8], 3'b011});
            chk(burst_lo[k] == e[7:0], "R4 copy start address", burst_lo[k], e[7:0]);
        end
        bad5 = 0; bad7 = 0;
        for (int i = 0; i < REG_BYTES; i++) begin
            if (snap[i] !== mem[base + i]) bad5++;
            if (shadow[i] !== exp_vote(base, i)) bad7++;
        end
        chk(run_rises == 1 && run == 1'b1, "R5 run raised once and held", run_rises, 1);
        chk(bad5 == 0, "R5 first copy applied at run", bad5, 0);
        chk(bad7 == 0, "R7 voted image", bad7, 0);
        chk(wr_count == 2 * REG_BYTES, "R7 write count", wr_count, 2 * REG_BYTES);
        chk(active == exp_vote(base, 10)[6], "R8 active from reg 10 bit 6",
            active, exp_vote(base, 10)[6]);
        chk(mosi_hi == 0, "R10 MOSI low in data phase", mosi_hi, 0);
        chk(hi_bad == 0 && cs_bad == 0, "R2 clock phases", hi_bad + cs_bad, 0);
    endtask

    task automatic abort_load(input int sel);
        int base, t;
        base = sel * AREA;
        fill(base, 0);
        reset_and_release(sel, base);
        t = 0;
        while (run_rises == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (60) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R6 second burst under way", spi_cs_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk({spi_cs_n, run, done, active} == 4'b1000, "R9 abort mid-transfer",
            int'({spi_cs_n, run, done, active}), 8);
    endtask

    initial begin
        void'($urandom(32'd13579));
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        run_load(5, 0);   // address >= 256, independent copies
        run_load(2, 3);   // address < 256, deviating first copy
        abort_load(3);
        run_load(6, 2);   // deviating third copy, restart after abort
        run_load(7, 1);   // identical copies, active bit clear
        run_load(0, 0);
        summary();
        $finish;
    end

endmodule